// File: doc/BRIEF.md
# Two-Operand NaN Result Selector

This block produces the result word of a single-precision two-input arithmetic operation once that operation has found that at least one of its operands is a NaN. It looks at both operands and decides for each whether it is a quiet NaN, a signaling NaN or an ordinary number. It then chooses one operand under one of several selectable propagation rules. If the chosen operand is signaling, it is turned into a quiet NaN. The block also raises the invalid-operation flag whenever a signaling NaN takes part.

A mode input replaces the chosen operand with a fixed default NaN. Even in that mode, the invalid flag still reports signaling inputs. The result and the flag are registered, so both appear one clock after the operands are presented. An arithmetic unit places this block beside its datapath and uses its output whenever its own special-case logic flags a NaN operand.

Top module: `nanprop_top`

## Requirements
- R1: A 32-bit operand is a NaN when its exponent field (bits 30:23) is all ones and its fraction (bits 22:0) is nonzero. The NaN is quiet when fraction bit 22 is 1 and signaling when bit 22 is 0.
- R2: `invalid_out` is 1 exactly when at least one operand is a signaling NaN. This holds under every rule and in both states of `dflt_mode`.
- R3: With `dflt_mode` high, `nan_out` is the default NaN 0x7FC00000, whatever the operands and `rule_sel`.
- R4: Rule encoding 2'b00 takes the first of these that applies: a if signaling, then b if signaling, then a if quiet, and otherwise b.
- R5: Rule encoding 2'b01 returns a whenever a is any NaN, and b otherwise.
- R6: Rule encoding 2'b10 works as follows. A signaling NaN against a quiet NaN yields the quiet one. A NaN against a non-NaN yields the NaN. Two NaNs of the same kind yield the one with the larger significand.
- R7: Under rule 2'b10, a has the larger significand when bits 30:0 of a exceed those of b. When bits 30:0 are equal, a counts as larger only if a is positive and b is negative.
- R8: The reserved rule encoding 2'b11 gives the same result as encoding 2'b00.
- R9: A signaling operand that is chosen is returned with bit 22 set and every other bit kept. A quiet operand that is chosen is returned unchanged, sign and payload included.
- R10: `nan_out` and `invalid_out` change one clock edge after their inputs. A rising clock edge with `rst_n` low clears both outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| rule_sel | input | 2 | Propagation rule: 0 ordered, 1 first NaN, 2 larger significand, 3 reserved (as 0) |
| dflt_mode | input | 1 | Force the default NaN as the result |
| nan_out | output | 32 | Registered result NaN |
| invalid_out | output | 1 | Registered invalid-operation flag |

## Verification
The assertions that check the quiet form of the result assume that at least one operand is a NaN, because that is the contract under which the block is used. With two ordinary numbers the selected word has no meaning. The stimulus keeps within this contract: it crosses every pair from a set of ordinary, quiet and signaling values under every rule and both modes, and skips pairs in which neither operand is a NaN. The value set includes pairs with equal magnitude and opposite sign, so that the tie-break path is exercised.

// File: rtl/nanprop_pkg.sv
// Shared types for the NaN result selector.
// Assumes IEEE-style binary words: sign, exponent, fraction.
package nanprop_pkg;

    // Propagation rule encodings; the reserved encoding behaves as RULE_ORDERED.
    typedef enum logic [1:0] {
        RULE_ORDERED   = 2'd0,
        RULE_FIRST_NAN = 2'd1,
        RULE_MAGNITUDE = 2'd2,
        RULE_RESERVED  = 2'd3
    } rule_e;

    // Operand classification flags.
    typedef struct packed {
        logic is_nan;
        logic is_quiet;
        logic is_sig;
    } nan_class_t;

endpackage

// File: rtl/nanprop_classify.sv
// Classifies one operand word as quiet NaN, signaling NaN or other.
// Assumes the most significant fraction bit marks a quiet NaN when set.
module nanprop_classify
    import nanprop_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] word_i,
    output nan_class_t        cls_o
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_full;

    assign exp_f  = word_i[WORD_W-2 -: EXP_W];
    assign frac_f = word_i[FRAC_W-1:0];

    // Decode the NaN class from the exponent and fraction fields.
    always_comb begin
        exp_full        = &exp_f;
        cls_o.is_nan    = exp_full && (|frac_f);
        cls_o.is_quiet  = exp_full && frac_f[FRAC_W-1];
        cls_o.is_sig    = exp_full && !frac_f[FRAC_W-1] && (|frac_f[FRAC_W-2:0]);
    end
endmodule

// File: rtl/nanprop_pick.sv
// Chooses which operand becomes the result under the selected rule.
// Output pick_b_o is 1 to select operand b, 0 to select operand a.
// Assumes at least one operand is a NaN; otherwise the choice is don't-care.
module nanprop_pick
    import nanprop_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] a_word_i,
    input  logic [WORD_W-1:0] b_word_i,
    input  nan_class_t        a_cls_i,
    input  nan_class_t        b_cls_i,
    input  rule_e             rule_i,
    output logic              pick_b_o
);
    logic [WORD_W-2:0] a_mag;
    logic [WORD_W-2:0] b_mag;
    logic              a_larger;

    assign a_mag = a_word_i[WORD_W-2:0];
    assign b_mag = b_word_i[WORD_W-2:0];

    // Larger-significand test; on equal magnitude the positive word wins.
    always_comb begin
        if (a_mag != b_mag) a_larger = (a_mag > b_mag);
        else                a_larger = (a_word_i < b_word_i);
    end

    // Rule-dependent operand choice.
    always_comb begin
        unique case (rule_i)
            RULE_FIRST_NAN: pick_b_o = !a_cls_i.is_nan;
            RULE_MAGNITUDE: begin
                if (a_cls_i.is_sig) begin
                    if (b_cls_i.is_sig) pick_b_o = !a_larger;
                    else                pick_b_o = b_cls_i.is_quiet;
                end else if (a_cls_i.is_quiet) begin
                    if (b_cls_i.is_sig || !b_cls_i.is_nan) pick_b_o = 1'b0;
                    else                                   pick_b_o = !a_larger;
                end else begin
                    pick_b_o = 1'b1;
                end
            end
            default: begin
                if (a_cls_i.is_sig)        pick_b_o = 1'b0;
                else if (b_cls_i.is_sig)   pick_b_o = 1'b1;
                else if (a_cls_i.is_quiet) pick_b_o = 1'b0;
                else                       pick_b_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/nanprop_quiet.sv
// Converts a signaling NaN into a quiet one by setting the top fraction bit.
// Assumes is_sig_i comes from the classifier for the same word.
module nanprop_quiet #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic              is_sig_i,
    output logic [WORD_W-1:0] word_o
);
    localparam logic [WORD_W-1:0] QUIET_MASK = WORD_W'(1) << (FRAC_W-1);

    // Set the quiet bit only for signaling input.
    always_comb begin
        word_o = is_sig_i ? (word_i | QUIET_MASK) : word_i;
    end
endmodule

// File: rtl/nanprop_top.sv
// Two-operand NaN result selector with a registered result and invalid flag.
// Assumes the caller uses the result only when at least one operand is a NaN.
module nanprop_top
    import nanprop_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] opnd_a,
    input  logic [WORD_W-1:0] opnd_b,
    input  logic [1:0]        rule_sel,
    input  logic              dflt_mode,
    output logic [WORD_W-1:0] nan_out,
    output logic              invalid_out
);
    localparam logic [WORD_W-1:0] DFLT_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] QUIET_MASK = WORD_W'(1) << (FRAC_W-1);

    logic [WORD_W-1:0] opnd [2];
    nan_class_t        cls  [2];
    logic              pick_b;
    logic [WORD_W-1:0] chosen;
    logic [WORD_W-1:0] quieted;
    logic              any_sig;

    assign opnd[0] = opnd_a;
    assign opnd[1] = opnd_b;

    // One classifier per operand.
    for (genvar gi = 0; gi < 2; gi++) begin : g_cls
        nanprop_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .word_i (opnd[gi]),
            .cls_o  (cls[gi])
        );
    end

    nanprop_pick #(.WORD_W(WORD_W)) u_pick (
        .a_word_i (opnd_a),
        .b_word_i (opnd_b),
        .a_cls_i  (cls[0]),
        .b_cls_i  (cls[1]),
        .rule_i   (rule_e'(rule_sel)),
        .pick_b_o (pick_b)
    );

    assign chosen  = pick_b ? opnd_b : opnd_a;
    assign any_sig = cls[0].is_sig || cls[1].is_sig;

    nanprop_quiet #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_quiet (
        .word_i   (chosen),
        .is_sig_i (pick_b ? cls[1].is_sig : cls[0].is_sig),
        .word_o   (quieted)
    );

    // Output register: default NaN in default mode, else the quieted choice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nan_out     <= '0;
            invalid_out <= 1'b0;
        end else begin
            nan_out     <= dflt_mode ? DFLT_NAN : quieted;
            invalid_out <= any_sig;
        end
    end

    // R2
    invalid_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (invalid_out == $past(cls[0].is_sig || cls[1].is_sig)));

    // R3
    default_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dflt_mode)) |-> (nan_out == DFLT_NAN));

    // R9
    result_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cls[0].is_nan || cls[1].is_nan))
        |-> ((&nan_out[WORD_W-2 -: EXP_W]) && nan_out[FRAC_W-1]));

    // R9
    quiet_bit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((quieted ^ chosen) & ~QUIET_MASK) == '0);

    // R5
    first_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rule_sel == 2'd1 && cls[0].is_nan) |-> !pick_b);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (nan_out == '0 && !invalid_out));
endmodule

// File: tb/nanprop_top_tb.sv
// Sweeps operand class pairs, rules and modes against an arithmetic model.
module nanprop_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [1:0]  rule_sel = '0;
    logic        dflt_mode = 1'b0;
    logic [31:0] nan_out;
    logic        invalid_out;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    nanprop_top u_dut (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .rule_sel(rule_sel), .dflt_mode(dflt_mode),
        .nan_out(nan_out), .invalid_out(invalid_out)
    );

    // Ordinary, quiet and signaling values; equal-magnitude pairs of opposite sign included.
    localparam logic [31:0] VALS [12] = '{
        32'h00000000, 32'h3F800000, 32'hFF800000, 32'h7F7FFFFF,
        32'h7FC00000, 32'hFFC00000, 32'hFFC00001, 32'h7FFFFFFF,
        32'h7F800001, 32'hFF800001, 32'hFFA00000, 32'h7FBFFFFF
    };

    // R1: class helpers
    function automatic bit is_q(logic [31:0] x);
        return (x[30:23] == 8'hFF) && x[22];
    endfunction
    function automatic bit is_s(logic [31:0] x);
        return (x[30:23] == 8'hFF) && !x[22] && (x[21:0] != 0);
    endfunction

    // R7: a wins on larger magnitude, or on equal magnitude when a positive and b negative
    function automatic bit a_wins(logic [31:0] a, logic [31:0] b);
        if (a[30:0] > b[30:0]) return 1;
        if (a[30:0] < b[30:0]) return 0;
        return (!a[31] && b[31]);
    endfunction

    function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b,
                                          int rule, bit dm);
        logic [31:0] r;
        bit aq = is_q(a), as_ = is_s(a), bq = is_q(b), bs = is_s(b);
        if (dm) return 32'h7FC00000;
        case (rule)
            1: r = (aq || as_) ? a : b;
            2: begin
                if ((as_ && bs) || (aq && bq)) r = a_wins(a, b) ? a : b;
                else if (aq || bq)             r = aq ? a : b;
                else                           r = as_ ? a : b;
            end
            default: r = as_ ? a : (bs ? b : (aq ? a : b));
        endcase
        if (is_s(r)) r[22] = 1'b1;   // R9
        return r;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        string tag;
        opnd_a = 32'h7F800001;
        opnd_b = 32'h7FC00000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10 reset nan_out", nan_out, 32'h0);
        chk("R10 reset invalid", {31'b0, invalid_out}, 32'h0);
        rst_n = 1'b1;
        for (int m = 0; m < 2; m++) begin
            for (int r = 0; r < 4; r++) begin
                for (int i = 0; i < 12; i++) begin
                    for (int j = 0; j < 12; j++) begin
                        if (i < 4 && j < 4) continue;
                        @(negedge clk);
                        opnd_a = VALS[i];
                        opnd_b = VALS[j];
                        rule_sel = 2'(r);
                        dflt_mode = bit'(m);
                        @(posedge clk);
                        @(negedge clk);
                        if (m == 1) tag = "R3";
                        else if (r == 0) tag = "R4/R9/R1";
                        else if (r == 1) tag = "R5/R9/R1";
                        else if (r == 3) tag = "R8/R9";
                        else if (VALS[i][30:0] == VALS[j][30:0]) tag = "R7/R6";
                        else tag = "R6/R9";
                        chk(tag, nan_out, model(VALS[i], VALS[j], r, bit'(m)));
                        chk("R2 invalid", {31'b0, invalid_out},
                            {31'b0, (is_s(VALS[i]) || is_s(VALS[j]))});
                    end
                end
            end
        end
        // R10: latency, output follows the new input after one edge
        @(negedge clk);
        dflt_mode = 1'b0; rule_sel = 2'd1;
        opnd_a = 32'hFFA00000; opnd_b = 32'h00000000;
        @(posedge clk);
        @(negedge clk);
        chk("R10 latency", nan_out, 32'hFFE00000);
        // R10: synchronous reset clears a live result
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R10 reset clear", nan_out, 32'h0);
        chk("R10 reset invalid clear", {31'b0, invalid_out}, 32'h0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule